// File: doc/BRIEF.md
# Cascaded Serializer Chain Read Controller

This block is a host-side master that reads back a chain of cascaded eight-input parallel-load serializers. A chain of `N_DEV` devices shares one serial return line. Each device's serial output feeds the serial input of its neighbour, and the last device in the chain drives the host. One read runs in two phases. First the controller drives an active-low load strobe, so every device latches its field inputs at the same moment. It then drops an active-low clock enable and produces `8*N_DEV` rising edges on a divided shift clock. Before each rising edge it samples the return line and builds one `8*N_DEV`-bit word.

The host side has a one-cycle start request, a busy flag and a one-cycle done pulse. The assembled word stays on the result port until the next read completes. The strobe width, the recovery time after the strobe, the enable-to-clock setup time and the shift-clock half period are all parameters counted in system-clock cycles. This lets the minimum device timings be met at any system clock rate.

Top module: `chain_reader`

## Requirements
- R1: After reset, and at any time busy is low, the load strobe and the clock enable are high (inactive) and the shift clock is low. After reset, busy, done and the result are all zero.
- R2: A start request sampled while idle drives the load strobe low from the next cycle for exactly `LOAD_CYC` cycles. The field data is captured only during that window, so field changes after it do not reach the result.
- R3: After the strobe returns high, the clock enable stays high for `REC_CYC` cycles and then stays low for `SETUP_CYC` cycles before clocking begins. The first rising shift-clock edge therefore comes `REC_CYC+SETUP_CYC+HALF_CYC` cycles after the strobe rises, and `SETUP_CYC+HALF_CYC` cycles after the enable falls.
- R4: The shift clock has low and high phases of exactly `HALF_CYC` system cycles each. Every read makes exactly `8*N_DEV` rising edges, and each rising edge occurs with the strobe high and the enable low.
- R5: The return line is sampled in the system cycle at whose end the shift clock rises. The first sample, taken before any edge, goes to result bit `8*N_DEV-1`. Each later sample goes one bit lower, and the last sample goes to bit 0.
- R6: The result equals the full chain contents captured by the strobe. Bits `8*N_DEV-1` down to `8*N_DEV-8` hold the device wired to the host, from its output stage inward. The next lower byte holds its upstream neighbour, and so on.
- R7: Busy is high from the cycle after an accepted start through the done cycle. Done is high for exactly one cycle per read, and the clock enable is back high in that same cycle.
- R8: A start request while busy is ignored: it produces no second strobe, no extra clock edges and no change to the result.
- R9: The result changes only in a done cycle and is held unchanged in between, whatever the field inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, sampled when idle |
| sdi_i | input | 1 | Serial return from the chain's host-side device |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse when the result is updated |
| data_o | output | 8*N_DEV | Assembled chain word, held between reads |
| ld_n_o | output | 1 | Active-low parallel load strobe to all devices |
| ce_n_o | output | 1 | Active-low shift clock enable to all devices |
| sclk_o | output | 1 | Divided shift clock to all devices |

## Verification
A behavioural two-device chain is loaded with several field patterns:
- All zeros and all ones catch stuck return sampling.
- Single set bits at the top and the bottom of the word, together with one-hot bytes, tell a correct bit order apart from a reversed or shifted one and from swapped devices.
- Alternating and random words catch dropped or duplicated samples.

Each read also measures the strobe width, the recovery and setup spacing, every clock phase and the edge count against the parameters. One read injects a second start while busy and scrambles the field inputs after the strobe. It is then followed by a hold period in which the field inputs change, which separates a correct design from one that reloads or restarts.

// File: rtl/crd_pkg.sv
package crd_pkg;

    localparam int unsigned DEV_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RECOV,
        ST_SETUP,
        ST_SHIFT,
        ST_DONE
    } crd_state_e;

    typedef struct packed {
        logic ld_n;
        logic ce_n;
    } crd_pins_t;

    // Bits needed to hold the value v (at least one).
    function automatic int unsigned cnt_width(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Device-side strobe levels for each sequencer state.
    function automatic crd_pins_t pins_for(input crd_state_e s);
        crd_pins_t p;
        p.ld_n = 1'b1;
        p.ce_n = 1'b1;
        case (s)
            ST_LOAD:  p.ld_n = 1'b0;
            ST_SETUP: p.ce_n = 1'b0;
            ST_SHIFT: p.ce_n = 1'b0;
            default:  ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/crd_interval.sv
module crd_interval #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/crd_sclk_gen.sv
module crd_sclk_gen
    import crd_pkg::*;
#(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_next,
    output logic fall_next
);
    localparam int unsigned PW = cnt_width(HALF_CYC - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

    logic [PW-1:0] ph_q;
    logic          sclk_q;
    logic          phase_end;

    assign phase_end = (ph_q == PH_LAST);
    assign rise_next = run && !sclk_q && phase_end;
    assign fall_next = run && sclk_q && phase_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q   <= '0;
            sclk_q <= 1'b0;
        end else if (phase_end) begin
            ph_q   <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            ph_q   <= ph_q + 1'b1;
        end
    end

    assign sclk = sclk_q;
endmodule

// File: rtl/crd_collect.sv
module crd_collect
    import crd_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  logic         sdi,
    output logic [W-1:0] word,
    output logic         full
);
    localparam int unsigned BW = cnt_width(W);
    localparam logic [BW-1:0] BITS_ALL = BW'(W);

    logic [W-1:0]  sh_q;
    logic [BW-1:0] n_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q <= '0;
            n_q  <= '0;
        end else if (sample) begin
            sh_q <= {sh_q[W-2:0], sdi};
            n_q  <= n_q + 1'b1;
        end
    end

    assign word = sh_q;
    assign full = (n_q == BITS_ALL);
endmodule

// File: rtl/chain_reader.sv
module chain_reader
    import crd_pkg::*;
#(
    parameter int unsigned N_DEV     = 2,
    parameter int unsigned HALF_CYC  = 2,
    parameter int unsigned LOAD_CYC  = 3,
    parameter int unsigned REC_CYC   = 2,
    parameter int unsigned SETUP_CYC = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_i,
    input  logic                        sdi_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [N_DEV*DEV_BITS-1:0]   data_o,
    output logic                        ld_n_o,
    output logic                        ce_n_o,
    output logic                        sclk_o
);
    localparam int unsigned W  = N_DEV * DEV_BITS;
    localparam int unsigned CW = cnt_width(max3(LOAD_CYC, REC_CYC, SETUP_CYC));
    localparam logic [CW-1:0] LOAD_V  = CW'(LOAD_CYC - 1);
    localparam logic [CW-1:0] REC_V   = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC - 1);

    crd_state_e    state_q, state_n;
    crd_pins_t     pins_q;
    logic          iv_load, iv_expired;
    logic [CW-1:0] iv_val;
    logic          rise_next, fall_next, sclk_int;
    logic          col_clear, col_full;
    logic [W-1:0]  col_word;
    logic [W-1:0]  data_q;
    logic          busy_q, done_q;

    crd_interval #(.CW(CW)) u_iv (
        .clk      (clk),
        .rst      (rst),
        .load     (iv_load),
        .load_val (iv_val),
        .expired  (iv_expired)
    );

    crd_sclk_gen #(.HALF_CYC(HALF_CYC)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == ST_SHIFT),
        .sclk      (sclk_int),
        .rise_next (rise_next),
        .fall_next (fall_next)
    );

    crd_collect #(.W(W)) u_col (
        .clk    (clk),
        .rst    (rst),
        .clear  (col_clear),
        .sample (rise_next),
        .sdi    (sdi_i),
        .word   (col_word),
        .full   (col_full)
    );

    assign col_clear = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_n = state_q;
        iv_load = 1'b0;
        iv_val  = '0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                state_n = ST_LOAD;
                iv_load = 1'b1;
                iv_val  = LOAD_V;
            end
            ST_LOAD: if (iv_expired) begin
                state_n = ST_RECOV;
                iv_load = 1'b1;
                iv_val  = REC_V;
            end
            ST_RECOV: if (iv_expired) begin
                state_n = ST_SETUP;
                iv_load = 1'b1;
                iv_val  = SETUP_V;
            end
            ST_SETUP: if (iv_expired) state_n = ST_SHIFT;
            ST_SHIFT: if (fall_next && col_full) state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= '{ld_n: 1'b1, ce_n: 1'b1};
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            pins_q  <= pins_for(state_n);
            busy_q  <= (state_n != ST_IDLE);
            done_q  <= (state_n == ST_DONE);
            if (state_q == ST_SHIFT && state_n == ST_DONE) data_q <= col_word;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign data_o = data_q;
    assign ld_n_o = pins_q.ld_n;
    assign ce_n_o = pins_q.ce_n;
    assign sclk_o = sclk_int;
endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
    parameter int unsigned N_DEV = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [N_DEV*8-1:0]   data_o,
    input logic                 ld_n_o,
    input logic                 ce_n_o,
    input logic                 sclk_o
);
    localparam int unsigned W = N_DEV * 8;

    int unsigned edge_cnt;
    logic        sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_cnt <= 0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_o;
            if (!busy_o)                edge_cnt <= 0;
            else if (sclk_o && !sclk_d) edge_cnt <= edge_cnt + 1;
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ld_n_o && ce_n_o && !sclk_o)); // R1
    AST_LOAD_BLOCKS_CLK: assert property (@(posedge clk) disable iff (rst)
        !ld_n_o |-> !sclk_o); // R2
    AST_RISE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (ld_n_o && !ce_n_o)); // R4
    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $rose(sclk_o)) |-> (edge_cnt < W)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_DONE_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_o && ce_n_o)); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(ld_n_o) |-> !$past(busy_o)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> done_o); // R9
endmodule

bind chain_reader crd_checker #(.N_DEV(N_DEV)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy_o (busy_o),
    .done_o (done_o),
    .data_o (data_o),
    .ld_n_o (ld_n_o),
    .ce_n_o (ce_n_o),
    .sclk_o (sclk_o)
);

// File: tb/chain_reader_tb.sv
module chain_reader_tb;
    localparam int N_DEV = 2;
    localparam int W = N_DEV * 8;
    localparam int HALF = 2;
    localparam int LOADC = 3;
    localparam int RECC = 2;
    localparam int SETC = 2;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sdi;
    logic busy_o, done_o, ld_n_o, ce_n_o, sclk_o;
    logic [W-1:0] data_o;
    logic [W-1:0] field = '0;
    logic [W-1:0] chain = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_reader #(.N_DEV(N_DEV), .HALF_CYC(HALF), .LOAD_CYC(LOADC),
                   .REC_CYC(RECC), .SETUP_CYC(SETC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .sdi_i(sdi),
        .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
        .ld_n_o(ld_n_o), .ce_n_o(ce_n_o), .sclk_o(sclk_o)
    );

    // Behavioural chain: MSB is the output stage of the host-side device.
    always @(negedge ld_n_o or posedge sclk_o) begin
        if (!ld_n_o)      chain <= field;
        else if (!ce_n_o) chain <= {chain[W-2:0], 1'b0};
    end
    assign sdi = chain[W-1];

    // Pin timing monitor, sampled mid-cycle.
    int m_loads, m_ldrun, m_ldlen, m_rc, m_rec, m_cecnt, m_setup;
    int m_edges, m_badph, m_run, m_donew;
    logic p_busy = 1'b0, p_ld = 1'b1, p_sclk = 1'b0;

    always @(negedge clk) begin
        cycles++;
        if (busy_o && !p_busy) begin
            m_loads = 0; m_ldrun = 0; m_ldlen = 0; m_rc = 0; m_rec = 0;
            m_cecnt = 0; m_setup = 0; m_edges = 0; m_badph = 0; m_run = 0;
            m_donew = 0;
        end
        if (!ld_n_o) m_ldrun++;
        if (!ld_n_o && p_ld) m_loads++;
        if (ld_n_o && !p_ld) m_ldlen = m_ldrun;
        if (busy_o && ld_n_o && m_ldlen != 0 && m_edges == 0 && !sclk_o) m_rc++;
        if (busy_o && !ce_n_o && m_edges == 0 && !sclk_o) m_cecnt++;
        if (sclk_o && !p_sclk) begin
            if (m_edges == 0) begin
                m_rec = m_rc;
                m_setup = m_cecnt;
            end else if (m_run != HALF) m_badph++;
            m_edges++;
            m_run = 1;
        end else if (!sclk_o && p_sclk) begin
            if (m_run != HALF) m_badph++;
            m_run = 1;
        end else begin
            m_run++;
        end
        if (done_o) m_donew++;
        p_busy = busy_o; p_ld = ld_n_o; p_sclk = sclk_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [W-1:0] f, input bit disturb);
        field = f;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy_o == 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
        if (disturb) begin
            repeat (6) @(negedge clk);
            field = ~f;                      // after the strobe: must not matter
            start = 1'b1;                    // while busy: must be ignored
            @(negedge clk); start = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(data_o == f, "R6", "chain word", 64'(data_o), 64'(f));
        chk(m_ldlen == LOADC, "R2", "strobe width", 64'(m_ldlen), 64'(LOADC));
        chk(m_rec == RECC + SETC + HALF, "R3", "strobe rise to first edge",
            64'(m_rec), 64'(RECC + SETC + HALF));
        chk(m_setup == SETC + HALF, "R3", "enable low to first edge",
            64'(m_setup), 64'(SETC + HALF));
        chk(m_edges == W, "R4", "edge count", 64'(m_edges), 64'(W));
        chk(m_badph == 0, "R4", "bad phase count", 64'(m_badph), 64'd0);
        chk(ce_n_o == 1'b1, "R7", "enable high at done", 64'(ce_n_o), 64'd1);
        if (disturb)
            chk(m_loads == 1, "R8", "strobes per read", 64'(m_loads), 64'd1);
        @(negedge clk);
        chk(done_o == 1'b0 && m_donew == 1, "R7", "done width",
            64'(m_donew), 64'd1);
        chk(busy_o == 1'b0, "R7", "busy after done", 64'(busy_o), 64'd0);
    endtask

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ld_n_o && ce_n_o && !sclk_o, "R1", "idle pins",
            64'({ld_n_o, ce_n_o, sclk_o}), 64'b110);
        chk(!busy_o && !done_o && data_o == '0, "R1", "idle status",
            64'({busy_o, done_o, data_o}), 64'd0);

        // Directed: R5 bit order and R6 device order
        xfer('0, 1'b0);
        xfer('1, 1'b0);
        xfer(W'(1) << (W-1), 1'b0);   // R5 first sample lands in the MSB
        xfer(W'(1), 1'b0);            // R5 last sample lands in bit 0
        xfer(W'(16'hA55A), 1'b0);
        xfer(W'(16'h00FF), 1'b0);     // R6 host-side device in the top byte
        // R8 start while busy, R2 field change after strobe
        xfer(W'(16'h3C81), 1'b1);

        // R9 hold with changing inputs, R1 idle pins
        held = data_o;
        for (int i = 0; i < 20; i++) begin
            field = W'($urandom);
            @(negedge clk);
        end
        chk(data_o == held, "R9", "result held", 64'(data_o), 64'(held));
        chk(ld_n_o && ce_n_o && !sclk_o && !busy_o, "R1", "idle pins later",
            64'({ld_n_o, ce_n_o, sclk_o, busy_o}), 64'b1100);

        // Random reads, R5 and R6
        for (int i = 0; i < 12; i++) begin
            xfer(W'($urandom), (i % 4) == 3);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule